// File: doc/BRIEF.md
# Latched-Status Interrupt Aggregator

This block merges the event strobes of up to 32 latching status registers into one interrupt line for a processor. Each source raises a one-cycle event when its status latches. The event sets that source's bit in a sticky match register. Bit k of the match register belongs to the k-th interrupt-capable source, counted in configuration order.

Software sees two words on a simple strobe bus. The first is a mask register that decides which sources may drive the interrupt. The second is the match register. Reading the match register returns its contents and clears it in the same access. The interrupt output works in one of two modes. In level mode it follows the masked match state. In pulse mode it gives one single-cycle pulse and then stays silent until software reads the match register.

Top module: `irq_aggregator`

## Requirements
- R1: A one on `src_evt[k]` in a cycle sets match bit k at that clock edge, so bit position k always corresponds to source k.
- R2: Match bits OR-accumulate. A later event never clears a bit that is already set, and an event on a bit that is already set leaves it set.
- R3: A read with `bus_addr == MATCH_ADDR` returns the match bits, zero-extended, on `bus_rdata` in the same cycle, and clears them at the next edge. An event that arrives in the same cycle as that read is kept in the register after the clear.
- R4: The mask register resets to all ones over NSRC bits. A write with `bus_addr == EN_ADDR` loads it from `bus_wdata[NSRC-1:0]`. A read at `EN_ADDR` returns it, zero-extended.
- R5: A source whose mask bit is 0 still sets its match bit, but it does not assert `irq` in either mode.
- R6: In level mode (`PULSE_MODE=0`), `irq` is high exactly when some match bit and its mask bit are both 1. This shows in the cycle after the edge that stored the event.
- R7: In pulse mode (`PULSE_MODE=1`), a pending unmasked match produces a pulse on `irq` that is exactly one clock wide. The pulse comes one cycle after the match becomes visible.
- R8: In pulse mode, no further pulse is produced after a pulse until the match register has been read. After that read, a new unmasked event produces a pulse again.
- R9: Synchronous active-high `rst` clears the match register and the pulse-blocking state. Writes to `MATCH_ADDR` have no effect. Reads at any address other than the two registers return 0.
- R10: The two register addresses are the parameters `EN_ADDR` and `MATCH_ADDR`, with defaults 0x00 and 0x04.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | NSRC | One-cycle latch events, one bit per source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of the match register clears it |
| bus_addr | input | AW | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| irq | output | 1 | Interrupt output, level or single pulse |

## Verification
A stuck or lost match bit shows at the ports at the next read of the match register. In level mode it also shows on `irq` one cycle after the event. A wrong mask bit shows on `irq` within one cycle of a masked or unmasked event, and on any read of the mask register. A pulse-blocking flag that is stuck set or stuck clear shows as a missing pulse, or as a second pulse, within two cycles of the next unmasked event.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NSRC = 32,
  parameter int AW = 8,
  parameter logic [AW-1:0] EN_ADDR = '0,
  parameter logic [AW-1:0] MATCH_ADDR = AW'(4),
  parameter bit PULSE_MODE = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_evt,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq
);
  logic [NSRC-1:0] match_q, en_q;

  wire en_sel   = (bus_addr == EN_ADDR);
  wire match_sel = (bus_addr == MATCH_ADDR);
  wire match_rd = bus_rd && match_sel;
  wire en_wr    = bus_wr && en_sel;
  wire pending  = |(match_q & en_q);
  wire unused_wdata = &{1'b0, bus_wdata};

  always_ff @(posedge clk) begin
    if (rst)           match_q <= '0;
    else if (match_rd) match_q <= src_evt;
    else               match_q <= match_q | src_evt;
  end

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '1;
    else if (en_wr) en_q <= bus_wdata[NSRC-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && en_sel)         bus_rdata = 32'(en_q);
    else if (bus_rd && match_sel) bus_rdata = 32'(match_q);
  end

  generate
    if (PULSE_MODE) begin : g_pulse
      logic blocked_q, pulse_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          blocked_q <= 1'b0;
          pulse_q   <= 1'b0;
        end else begin
          pulse_q <= pending && !blocked_q && !match_rd;
          if (match_rd)                             blocked_q <= 1'b0;
          else if (pending && !blocked_q)           blocked_q <= 1'b1;
        end
      end
      assign irq = pulse_q;
    end else begin : g_level
      assign irq = pending;
    end
  endgenerate
endmodule

module irq_aggregator_chk #(
  parameter int NSRC = 32,
  parameter int AW = 8,
  parameter logic [AW-1:0] EN_ADDR = '0,
  parameter logic [AW-1:0] MATCH_ADDR = AW'(4),
  parameter bit PULSE_MODE = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_evt,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic            irq,
  input logic [NSRC-1:0] match_q,
  input logic [NSRC-1:0] en_q
);
  AST_EVENT_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
    (|src_evt) |=> ((match_q & $past(src_evt)) == $past(src_evt))); // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == MATCH_ADDR && src_evt == '0) |=> (match_q == '0)); // R3
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == EN_ADDR) |=> $stable(en_q)); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (match_q == '0)); // R9
  generate
    if (PULSE_MODE) begin : g_p
      AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R7
    end else begin : g_l
      AST_LEVEL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == MATCH_ADDR && src_evt == '0) |=> !irq); // R6
    end
  endgenerate
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NSRC(NSRC), .AW(AW), .EN_ADDR(EN_ADDR), .MATCH_ADDR(MATCH_ADDR), .PULSE_MODE(PULSE_MODE)
) chk_i (
  .clk(clk), .rst(rst), .src_evt(src_evt), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .irq(irq), .match_q(match_q), .en_q(en_q)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb_top;
  localparam int N = 4;
  localparam logic [7:0] ENA = 8'h00;
  localparam logic [7:0] MTA = 8'h04;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_evt = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_l, rdata_p;
  logic irq_l, irq_p;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator #(.NSRC(N), .AW(8), .PULSE_MODE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .src_evt(src_evt), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_l), .irq(irq_l));
  irq_aggregator #(.NSRC(N), .AW(8), .PULSE_MODE(1'b1)) dut_pulse_i (
    .clk(clk), .rst(rst), .src_evt(src_evt), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_p), .irq(irq_p));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic evt(logic [N-1:0] p);
    src_evt = p; @(negedge clk); src_evt = '0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [N-1:0] ev, output logic [31:0] dl, output logic [31:0] dp);
    bus_rd = 1'b1; bus_addr = a; src_evt = ev;
    #1 dl = rdata_l; dp = rdata_p;
    @(negedge clk); bus_rd = 1'b0; src_evt = '0;
  endtask

  initial begin
    logic [31:0] dl, dp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 reset irq level", irq_l, 0);
    chk("R9 reset irq pulse", irq_p, 0);
    rd(ENA, '0, dl, dp); chk("R4 mask reset all ones", dl, 32'hF);
    rd(MTA, '0, dl, dp); chk("R9 match reset zero", dl, 0);

    // Level-mode sweep over every mask and every event pattern
    for (int m = 0; m < 16; m++) begin
      wr(ENA, 32'(m));
      rd(ENA, '0, dl, dp); chk("R4 mask readback", dl, 32'(m));
      for (int p = 1; p < 16; p++) begin
        evt(N'(p));
        chk("R6 R5 level irq", irq_l, 32'((m & p) != 0));
        rd(MTA, '0, dl, dp); chk("R1 R3 match read", dl, 32'(p));
        chk("R3 cleared irq", irq_l, 0);
      end
    end

    // R2 accumulation
    rst = 1'b1; idle(); rst = 1'b0;
    evt(4'h1); evt(4'h4); evt(4'h1);
    rd(MTA, '0, dl, dp); chk("R2 accumulate", dl, 32'h5);
    rd(MTA, '0, dl, dp); chk("R3 cleared after read", dl, 0);

    // Pulse mode
    rst = 1'b1; idle(); rst = 1'b0;
    evt(4'h1);
    chk("R7 no pulse yet", irq_p, 0);
    idle(); chk("R7 pulse", irq_p, 1);
    idle(); chk("R7 one wide", irq_p, 0);
    evt(4'h2); chk("R8 blocked a", irq_p, 0);
    idle(); chk("R8 blocked b", irq_p, 0);
    idle(); chk("R8 blocked c", irq_p, 0);
    rd(MTA, '0, dl, dp); chk("R2 pulse match", dp, 32'h3);
    evt(4'h4); idle(); chk("R8 rearm pulse", irq_p, 1);
    rd(MTA, 4'h8, dl, dp); chk("R3 read with event", dp, 32'h4);
    chk("R8 no pulse during read", irq_p, 0);
    idle(); chk("R3 R8 kept event pulses", irq_p, 1);
    rd(MTA, '0, dl, dp); chk("R3 event kept", dp, 32'h8);
    chk("R3 kept level", dl, 32'h8);

    // Masked source in pulse mode
    wr(ENA, 32'h0);
    evt(4'h1); idle(); chk("R5 masked no pulse", irq_p, 0);
    idle(); chk("R5 masked no pulse b", irq_p, 0);
    rd(MTA, '0, dl, dp); chk("R5 masked still sets", dp, 32'h1);

    // Ignored writes, unmapped reads, mask width
    evt(4'h2);
    wr(MTA, 32'hF);
    rd(MTA, '0, dl, dp); chk("R9 match write ignored", dl, 32'h2);
    rd(8'h08, '0, dl, dp); chk("R9 unmapped read", dl, 0);
    wr(8'h08, 32'h3);
    rd(ENA, '0, dl, dp); chk("R10 other addr no mask write", dl, 0);
    wr(ENA, 32'hFFFF_FFF5);
    rd(ENA, '0, dl, dp); chk("R4 mask width", dl, 32'h5);

    // Reset mid-run clears match
    evt(4'h3);
    rst = 1'b1; idle(); rst = 1'b0;
    rd(MTA, '0, dl, dp); chk("R9 reset clears match", dl, 0);
    chk("R9 reset pulse state", irq_p, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule